// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block runs once per transfer, after the START condition. It takes the first byte shifted in from the bus and decides whether that byte selects this slave. The byte holds a 7-bit address in bits 7:1 and the read/write bit in bit 0. An upstream deserializer supplies the byte together with a one-cycle valid strobe.

Several targets are checked against the byte in parallel:

- a primary own address, compared exactly;
- a secondary own address, whose low bits are ignored in graded steps set by a 3-bit mask code;
- the general-call address;
- three SMBus special addresses, each gated by a mode or enable input.

All outputs are registered and appear one clock after the strobe. On a hit the block produces:

- a one-cycle match pulse and an ACK request for the bit-level engine;
- the direction bit, captured from the read/write bit;
- a sticky address-matched flag, which stays set until a clear pulse;
- a code naming which target hit.

When more than one target hits, a fixed priority picks the code. A byte that hits nothing leaves every output unchanged, apart from the pulse outputs.

Top module: `i2c_addr_match`

## Requirements
- R1: When `addr_byte[7:1]` equals `pri_addr`, the byte matches with hit code 1.
- R2: When `sec_en` is 1 and `sec_mask` is k in 0..6, the byte matches the secondary address with hit code 2 if the address bits k through 6 equal the same bits of `sec_addr`. The address bits below k are ignored.
- R3: When `sec_en` is 1 and `sec_mask` is 7, every address matches the secondary address except the reserved groups 0000xxx and 1111xxx.
- R4: Address 0000000 (general call) matches with hit code 3 only while `gc_en` is 1.
- R5: Address 1100001 (SMBus device default) matches with hit code 4 only while `smb_dev_mode` is 1.
- R6: Address 0001000 (SMBus host) matches with hit code 5 only while both `smb_host_mode` and `smb_host_en` are 1.
- R7: Address 0001100 (SMBus alert response) matches with hit code 6 only while both `smb_host_mode` and `smb_alert_en` are 1.
- R8: On a match, `match_pulse` and `ack_req` are high for exactly the one cycle after the strobe. In that same cycle `addr_flag` is set and `dir` takes `addr_byte[0]`: 0 means the slave receives and 1 means the slave transmits.
- R9: A strobe whose byte matches nothing leaves `match_pulse` and `ack_req` low, and leaves `addr_flag`, `dir` and `hit_code` unchanged. With no strobe present, `addr_byte` is ignored.
- R10: `addr_flag` stays set until `flag_clr` is high at a clock edge. If a match and a clear arrive at the same edge, the flag remains set.
- R11: When several targets match at once, `hit_code` takes the first of: primary (1), secondary (2), general call (3), SMBus device (4), SMBus host (5), SMBus alert (6). Code 0 means no hit has been recorded since reset.
- R12: Synchronous active-high `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | One-cycle strobe: `addr_byte` holds a received address byte |
| addr_byte | input | 8 | Address in bits 7:1, read/write bit in bit 0 |
| flag_clr | input | 1 | Clears `addr_flag` |
| pri_addr | input | 7 | Primary own address |
| sec_en | input | 1 | Enables the secondary own address |
| sec_addr | input | 7 | Secondary own address |
| sec_mask | input | 3 | Secondary mask code, 0..7 |
| gc_en | input | 1 | Enables general-call matching |
| smb_dev_mode | input | 1 | SMBus device mode |
| smb_host_mode | input | 1 | SMBus host mode |
| smb_host_en | input | 1 | Enables the SMBus host address while in host mode |
| smb_alert_en | input | 1 | Enables the SMBus alert-response address while in host mode |
| match_pulse | output | 1 | One-cycle pulse on a match |
| ack_req | output | 1 | One-cycle ACK request on a match |
| dir | output | 1 | Direction captured at the last match |
| addr_flag | output | 1 | Sticky address-matched flag |
| hit_code | output | 3 | Which target the last match hit |

## Verification
For each secondary mask code, the bench applies two bytes: one that flips the highest ignored bit, which must still match, and one that flips the lowest compared bit, which must miss. Together these pin down the exact boundary of every code.

With mask code 7, the bench sweeps all 128 addresses in both directions. This separates the reserved groups from the accepted ones.

Each special address is applied with its gate on and with its gate off. Overlapping configurations, such as the primary address equal to the secondary address or an SMBus address also covered by the secondary mask, expose the priority order. Clear pulses placed before, alongside and after matches check that the flag is sticky and that a simultaneous set wins over a clear. A long randomized run with biased addresses and configurations is compared against a behavioural model on every clock.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int AW     = 7;
    localparam int MASK_W = 3;
    localparam int RSV_W  = 4;

    localparam logic [AW-1:0] GC_ADDR        = 7'b0000000;
    localparam logic [AW-1:0] SMB_DEV_ADDR   = 7'b1100001;
    localparam logic [AW-1:0] SMB_HOST_ADDR  = 7'b0001000;
    localparam logic [AW-1:0] SMB_ALERT_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        HIT_NONE      = 3'd0,
        HIT_PRI       = 3'd1,
        HIT_SEC       = 3'd2,
        HIT_GC        = 3'd3,
        HIT_SMB_DEV   = 3'd4,
        HIT_SMB_HOST  = 3'd5,
        HIT_SMB_ALERT = 3'd6
    } hit_e;

    typedef struct packed {
        logic [AW-1:0]     pri_addr;
        logic              sec_en;
        logic [AW-1:0]     sec_addr;
        logic [MASK_W-1:0] sec_mask;
        logic              gc_en;
        logic              smb_dev_mode;
        logic              smb_host_mode;
        logic              smb_host_en;
        logic              smb_alert_en;
    } am_cfg_t;

    // Address groups the bus keeps for itself (all-zero or all-one upper nibble).
    function automatic logic is_reserved(input logic [AW-1:0] a);
        return (a[AW-1 -: RSV_W] == '0) || (a[AW-1 -: RSV_W] == '1);
    endfunction

endpackage

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
    import i2c_am_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  am_cfg_t       cfg,
    output hit_e          hit
);

    // Per-bit compare qualifier: bit i is compared when i >= mask code.
    logic [AW-1:0] care;
    logic [AW-1:0] diff;

    genvar gi;
    generate
        for (gi = 0; gi < AW; gi++) begin : g_care
            assign care[gi] = (MASK_W'(gi) >= cfg.sec_mask);
            assign diff[gi] = addr[gi] ^ cfg.sec_addr[gi];
        end
    endgenerate

    logic pri_hit, sec_hit, gc_hit, dev_hit, host_hit, alert_hit;
    logic all_ones_code;

    assign all_ones_code = (cfg.sec_mask == '1);

    always_comb begin
        pri_hit   = (addr == cfg.pri_addr);
        if (all_ones_code)
            sec_hit = cfg.sec_en && !is_reserved(addr);
        else
            sec_hit = cfg.sec_en && ((diff & care) == '0);
        gc_hit    = cfg.gc_en && (addr == GC_ADDR);
        dev_hit   = cfg.smb_dev_mode && (addr == SMB_DEV_ADDR);
        host_hit  = cfg.smb_host_mode && cfg.smb_host_en && (addr == SMB_HOST_ADDR);
        alert_hit = cfg.smb_host_mode && cfg.smb_alert_en && (addr == SMB_ALERT_ADDR);
    end

    always_comb begin
        if (pri_hit)        hit = HIT_PRI;
        else if (sec_hit)   hit = HIT_SEC;
        else if (gc_hit)    hit = HIT_GC;
        else if (dev_hit)   hit = HIT_SMB_DEV;
        else if (host_hit)  hit = HIT_SMB_HOST;
        else if (alert_hit) hit = HIT_SMB_ALERT;
        else                hit = HIT_NONE;
    end

endmodule

// File: rtl/i2c_am_status.sv
module i2c_am_status
    import i2c_am_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic rw,
    input  hit_e hit,
    input  logic clr,
    output logic match_pulse,
    output logic ack_req,
    output logic dir,
    output logic flag,
    output hit_e code
);

    logic take;
    assign take = vld && (hit != HIT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_pulse <= 1'b0;
            ack_req     <= 1'b0;
            dir         <= 1'b0;
            flag        <= 1'b0;
            code        <= HIT_NONE;
        end else begin
            match_pulse <= take;
            ack_req     <= take;
            if (take) begin
                dir  <= rw;
                code <= hit;
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    // R8: a request is only ever the echo of a strobe one cycle earlier
    p_ack_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> $past(vld));

    // R8: a match always leaves the flag set
    p_flag_on_match_r8: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> flag);

    // R10: the flag holds unless cleared
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(flag) && !$past(clr)) |-> flag);

    // R9: direction and code move only with a match
    p_dir_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !match_pulse |-> ($stable(dir) && $stable(code)));

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         addr_vld,
    input  logic [7:0]   addr_byte,
    input  logic         flag_clr,
    input  logic [6:0]   pri_addr,
    input  logic         sec_en,
    input  logic [6:0]   sec_addr,
    input  logic [2:0]   sec_mask,
    input  logic         gc_en,
    input  logic         smb_dev_mode,
    input  logic         smb_host_mode,
    input  logic         smb_host_en,
    input  logic         smb_alert_en,
    output logic         match_pulse,
    output logic         ack_req,
    output logic         dir,
    output logic         addr_flag,
    output logic [2:0]   hit_code
);

    am_cfg_t cfg;
    hit_e    hit;
    hit_e    code_q;

    assign cfg = '{pri_addr:      pri_addr,
                   sec_en:        sec_en,
                   sec_addr:      sec_addr,
                   sec_mask:      sec_mask,
                   gc_en:         gc_en,
                   smb_dev_mode:  smb_dev_mode,
                   smb_host_mode: smb_host_mode,
                   smb_host_en:   smb_host_en,
                   smb_alert_en:  smb_alert_en};

    i2c_am_decode u_decode (
        .addr (addr_byte[7:1]),
        .cfg  (cfg),
        .hit  (hit)
    );

    i2c_am_status u_status (
        .clk         (clk),
        .rst         (rst),
        .vld         (addr_vld),
        .rw          (addr_byte[0]),
        .hit         (hit),
        .clr         (flag_clr),
        .match_pulse (match_pulse),
        .ack_req     (ack_req),
        .dir         (dir),
        .flag        (addr_flag),
        .code        (code_q)
    );

    assign hit_code = code_q;

    // R11: a recorded match never reports the empty code
    p_code_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (hit_code != 3'd0));

    // R8: the direction seen after a match is the strobed read/write bit
    p_dir_capture_r8: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (dir == $past(addr_byte[0])));

    // R1: primary equality always wins the code
    p_primary_first_r1: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && addr_byte[7:1] == pri_addr) |=> (match_pulse && hit_code == 3'd1));

endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_vld = 1'b0;
    logic [7:0] addr_byte = '0;
    logic       flag_clr = 1'b0;
    logic [6:0] pri_addr = 7'h50;
    logic       sec_en = 1'b0;
    logic [6:0] sec_addr = 7'h00;
    logic [2:0] sec_mask = 3'd0;
    logic       gc_en = 1'b0;
    logic       smb_dev_mode = 1'b0;
    logic       smb_host_mode = 1'b0;
    logic       smb_host_en = 1'b0;
    logic       smb_alert_en = 1'b0;
    logic       match_pulse, ack_req, dir, addr_flag;
    logic [2:0] hit_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_match dut (
        .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr_byte(addr_byte),
        .flag_clr(flag_clr), .pri_addr(pri_addr), .sec_en(sec_en),
        .sec_addr(sec_addr), .sec_mask(sec_mask), .gc_en(gc_en),
        .smb_dev_mode(smb_dev_mode), .smb_host_mode(smb_host_mode),
        .smb_host_en(smb_host_en), .smb_alert_en(smb_alert_en),
        .match_pulse(match_pulse), .ack_req(ack_req), .dir(dir),
        .addr_flag(addr_flag), .hit_code(hit_code)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R12";
    bit    started = 0;
    bit    done = 0;

    // Behavioural reference state
    int m_match = 0, m_dir = 0, m_flag = 0, m_code = 0;

    function automatic int ref_hit(int a);
        int hi;
        if (a == int'(pri_addr)) return 1;
        if (sec_en) begin
            if (sec_mask == 3'd7) begin
                hi = a / 8;
                if (hi != 0 && hi != 15) return 2;
            end else if ((a / (1 << sec_mask)) == (int'(sec_addr) / (1 << sec_mask))) begin
                return 2;
            end
        end
        if (gc_en && a == 0) return 3;
        if (smb_dev_mode && a == 'h61) return 4;
        if (smb_host_mode && smb_host_en && a == 'h08) return 5;
        if (smb_host_mode && smb_alert_en && a == 'h0C) return 6;
        return 0;
    endfunction

    always @(posedge clk) begin
        int h;
        started <= 1;
        if (rst) begin
            m_match = 0; m_dir = 0; m_flag = 0; m_code = 0;
        end else begin
            h = addr_vld ? ref_hit(int'(addr_byte[7:1])) : 0;
            m_match = (h != 0) ? 1 : 0;
            if (h != 0) begin
                m_dir = int'(addr_byte[0]); m_code = h; m_flag = 1;
            end else if (flag_clr) begin
                m_flag = 0;
            end
        end
    end

    task automatic chk(string name, int act, int exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            n_vec++;
            chk("match_pulse", int'(match_pulse), m_match);
            chk("ack_req",     int'(ack_req),     m_match);
            chk("dir",         int'(dir),         m_dir);
            chk("addr_flag",   int'(addr_flag),   m_flag);
            chk("hit_code",    int'(hit_code),    m_code);
        end
    end

    task automatic put(input logic [6:0] a, input logic rw, input string req);
        @(posedge clk); #1;
        cur_req   = req;
        addr_vld  = 1'b1;
        addr_byte = {a, rw};
        @(posedge clk); #1;
        addr_vld  = 1'b0;
        addr_byte = $urandom;
    endtask

    task automatic clr_pulse(input string req);
        @(posedge clk); #1;
        cur_req  = req;
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
    endtask

    task automatic cfg_off();
        sec_en = 0; gc_en = 0; smb_dev_mode = 0; smb_host_mode = 0;
        smb_host_en = 0; smb_alert_en = 0; pri_addr = 7'h50;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R12: reset state compared on the cycles above
        // R1: primary, both directions, and a near miss
        put(7'h50, 1'b0, "R1");
        put(7'h50, 1'b1, "R1");
        put(7'h51, 1'b0, "R9");
        clr_pulse("R10");
        put(7'h33, 1'b1, "R9");
        // R2: secondary boundary per mask code
        sec_en = 1; sec_addr = 7'h5A; pri_addr = 7'h01;
        for (int k = 0; k < 7; k++) begin
            sec_mask = 3'(k);
            put((k > 0) ? (sec_addr ^ 7'(1 << (k-1))) : sec_addr, 1'b1, "R2");
            put(sec_addr ^ 7'(1 << k), 1'b0, "R2");
            clr_pulse("R10");
        end
        // R3: mask code 7 sweep
        sec_mask = 3'd7; pri_addr = 7'h00;
        for (int a = 0; a < 128; a++) put(7'(a), a[0], "R3");
        // R4..R7: special addresses gated
        cfg_off();
        put(7'h00, 1'b0, "R4"); gc_en = 1; put(7'h00, 1'b1, "R4");
        put(7'h61, 1'b0, "R5"); smb_dev_mode = 1; put(7'h61, 1'b0, "R5");
        put(7'h08, 1'b1, "R6"); smb_host_mode = 1; put(7'h08, 1'b1, "R6");
        smb_host_en = 1; put(7'h08, 1'b0, "R6");
        put(7'h0C, 1'b1, "R7"); smb_alert_en = 1; put(7'h0C, 1'b1, "R7");
        smb_host_mode = 0; put(7'h0C, 1'b0, "R7"); put(7'h08, 1'b0, "R6");
        // R11: overlapping targets
        smb_host_mode = 1; sec_en = 1; sec_mask = 3'd6; sec_addr = 7'h00;
        put(7'h08, 1'b0, "R11"); put(7'h61, 1'b1, "R11");
        pri_addr = 7'h08; put(7'h08, 1'b1, "R11");
        sec_mask = 3'd0; sec_addr = 7'h0C; put(7'h0C, 1'b0, "R11");
        // R10: clear and match at the same edge, then clear alone
        @(posedge clk); #1;
        cur_req = "R10"; flag_clr = 1; addr_vld = 1; addr_byte = {7'h0C, 1'b1};
        @(posedge clk); #1;
        flag_clr = 0; addr_vld = 0;
        clr_pulse("R10");
        // R9: byte ignored without strobe
        @(posedge clk); #1; cur_req = "R9"; addr_byte = {7'h0C, 1'b0};
        repeat (3) @(posedge clk);
        // Randomized mix
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #1;
            cur_req = "R11";
            pri_addr = $urandom; sec_en = $urandom; sec_addr = $urandom;
            sec_mask = $urandom; gc_en = $urandom; smb_dev_mode = $urandom;
            smb_host_mode = $urandom; smb_host_en = $urandom; smb_alert_en = $urandom;
            flag_clr = ($urandom % 4 == 0);
            addr_vld = $urandom;
            case ($urandom % 6)
                0: addr_byte = {pri_addr, 1'($urandom)};
                1: addr_byte = {sec_addr ^ 7'($urandom % 8), 1'($urandom)};
                2: addr_byte = {7'h00, 1'($urandom)};
                3: addr_byte = {7'h61, 1'($urandom)};
                4: addr_byte = {(($urandom % 2) != 0) ? 7'h08 : 7'h0C, 1'($urandom)};
                default: addr_byte = $urandom;
            endcase
        end
        @(posedge clk); #1; addr_vld = 0; flag_clr = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        finish_run();
    end

endmodule